// File: doc/BRIEF.md
# Command Block Fetch and Decode Engine

This engine turns a memory-resident command block into a transfer descriptor for a disk-style controller. A single-cycle start strobe, together with the block's base address, launches a fetch of six consecutive 16-bit words over a request/grant memory port. The engine keeps at most one read in flight, keeps the request and address steady until the grant arrives, and stores each returned word in order.

Once the sixth word is captured, the engine decodes the words in one cycle. It extracts the operation, the drive unit, the requested format bits, a 24-bit memory address and a 24-bit transfer count. The count can be given in words or in sectors. The engine also computes a byte-granular device offset, taking the sector size from a per-unit size input. It then checks that the unit has media and that the operation is supported. If both checks pass, it pulses `done` and the downstream sequencer takes the descriptor. If either fails, it pulses `err` with a reason code. Start strobes that arrive while a command is in progress are ignored.

Top module: `cmdblk_fetch`

## Requirements
- R1: After an accepted start, the engine reads addresses base+0 through base+5 in ascending order, with one read outstanding at a time. `mem_req` and `mem_addr` stay unchanged until `mem_gnt` is seen high at a clock edge.
- R2: `d_maddr` equals {word2[7:0], word3}. The upper byte of word 2 is not part of this value.
- R3: Let C be {word4[7:0], word5}. When word4 bit 15 is 1, `d_wcnt` = C. When that bit is 0, C counts sectors and `d_wcnt` = C × 256 for 512-byte units or C × 512 for 1024-byte units, truncated to 24 bits.
- R4: `d_devoff` (34 bits) equals the 24-bit sector number {word2[15:8], word1} multiplied by 512, or by 1024 when the selected unit's `unit_1k` bit is 1.
- R5: The opcode is word0[5:0] and `d_unit` is word0[7:6]. `d_fmt` carries word0[11:8]. `d_op` is 0 for opcode 0 (read), 1 for opcode octal 36 (extended status) and 2 for opcode octal 42 (read format).
- R6: Rejections are checked in priority order. A unit whose `unit_present` bit is 0 gives `err_code` 1. Otherwise opcode 1 (write) gives `err_code` 2 (write-protected). Otherwise any opcode other than 0, 1, octal 36 or octal 42 gives `err_code` 3.
- R7: Exactly one of `done` or `err` pulses, for one cycle, per accepted command. The pulse comes in the cycle after the edge that captures word 5, and `busy` falls at the following edge.
- R8: A start strobe while `busy` is high has no effect on the fetch addresses, the decoded result or the number of completion pulses.
- R9: After reset, `busy`, `mem_req`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, honoured only when idle |
| base_addr | input | AW | Word address of the command block |
| unit_present | input | 4 | Media-attached flag per unit |
| unit_1k | input | 4 | Per unit: 1 = 1024-byte sectors, 0 = 512-byte |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read word address |
| mem_gnt | input | 1 | Read granted; data valid this cycle |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse: descriptor valid |
| err | output | 1 | One-cycle pulse: command rejected |
| err_code | output | 2 | Rejection reason, valid with err |
| d_op | output | 2 | Decoded operation |
| d_unit | output | 2 | Drive unit |
| d_fmt | output | 4 | Requested format bits |
| d_maddr | output | 24 | Memory word address |
| d_wcnt | output | 24 | Transfer length in words |
| d_devoff | output | 34 | Device byte offset |

## Verification
With a grant latency of L cycles, each word takes L+1 clock edges. The completion pulse therefore appears in the cycle after edge 6·(L+1), counted from the edge that accepts start, and `busy` drops one edge later. The bench counts falling edges from the accepting edge. It requires the pulse exactly at that count and compares the descriptor or reason code in that same cycle. It checks the quiet state one cycle later. The memory model checks every granted address against the expected ascending sequence at the moment of grant, while extra start strobes are injected mid-fetch.

// File: rtl/cmdblk_fetch.sv
module cmdblk_fetch #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [3:0]    unit_present,
  input  logic [3:0]    unit_1k,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic [15:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_code,
  output logic [1:0]    d_op,
  output logic [1:0]    d_unit,
  output logic [3:0]    d_fmt,
  output logic [23:0]   d_maddr,
  output logic [23:0]   d_wcnt,
  output logic [33:0]   d_devoff
);
  localparam int NW = 6;
  localparam int IW = $clog2(NW);
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK} st_t;
  st_t st;
  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;
  logic [15:0]   wd [NW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      base_q <= '0;
      for (int i = 0; i < NW; i++) wd[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q <= base_addr;
          idx    <= '0;
          st     <= S_FETCH;
        end
        S_FETCH: if (mem_gnt) begin
          wd[idx] <= mem_rdata;
          if (idx == LAST) st <= S_CHECK;
          else             idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == S_FETCH);
  assign mem_addr = base_q + AW'(idx);
  assign busy     = (st != S_IDLE);

  logic [5:0]  opc;
  logic        big;
  logic [23:0] cnt, secno;
  logic        unused_bits;

  assign opc      = wd[0][5:0];
  assign d_unit   = wd[0][7:6];
  assign d_fmt    = wd[0][11:8];
  assign big      = unit_1k[d_unit];
  assign d_maddr  = {wd[2][7:0], wd[3]};
  assign cnt      = {wd[4][7:0], wd[5]};
  assign secno    = {wd[2][15:8], wd[1]};
  assign d_wcnt   = wd[4][15] ? cnt : (big ? {cnt[14:0], 9'b0} : {cnt[15:0], 8'b0});
  assign d_devoff = big ? {secno, 10'b0} : {1'b0, secno, 9'b0};
  assign unused_bits = ^{wd[0][15:12], wd[4][14:8]};

  always_comb begin
    d_op = 2'd0;
    if (opc == 6'o36) d_op = 2'd1;
    if (opc == 6'o42) d_op = 2'd2;
    if (!unit_present[d_unit])                           err_code = 2'd1;
    else if (opc == 6'o01)                               err_code = 2'd2;
    else if (opc != 6'o00 && opc != 6'o36 && opc != 6'o42) err_code = 2'd3;
    else                                                 err_code = 2'd0;
  end

  assign done = (st == S_CHECK) && (err_code == 2'd0);
  assign err  = (st == S_CHECK) && (err_code != 2'd0);
endmodule

module cmdblk_fetch_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] base_addr,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          busy,
  input logic          done,
  input logic          err
);
  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> !mem_req || (mem_addr == $past(mem_addr) + 1'b1));
  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !(done || err) && !busy);
  // R8
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> mem_req && (mem_addr == $past(base_addr)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done && !err);
endmodule

bind cmdblk_fetch cmdblk_fetch_chk #(.AW(AW)) u_chk (.*);

// File: tb/cmdblk_fetch_tb.sv
`timescale 1ns/1ps
module cmdblk_fetch_tb;
  logic        clk = 0, rst_n = 0, start = 0, mem_gnt = 0;
  logic [23:0] base_addr = '0, mem_addr;
  logic [3:0]  unit_present = 4'b0111, unit_1k = 4'b0101;
  logic [15:0] mem_rdata = '0;
  logic        mem_req, busy, done, err;
  logic [1:0]  err_code, d_op, d_unit;
  logic [3:0]  d_fmt;
  logic [23:0] d_maddr, d_wcnt;
  logic [33:0] d_devoff;

  int checks = 0, errors = 0;
  logic [15:0] mem [64];
  int lat = 0, lat_cnt = 0, k = 0;
  logic [23:0] exp_base = '0;

  always #2.5 clk = ~clk;

  cmdblk_fetch u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_req) begin
      if (lat_cnt == lat) begin
        chk(mem_addr == exp_base + 24'(k), "R1 addr", mem_addr, exp_base + 24'(k));
        mem_gnt   <= 1;
        mem_rdata <= mem[mem_addr[5:0]];
        lat_cnt   <= 0;
        k         <= k + 1;
      end else begin
        mem_gnt <= 0;
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_gnt <= 0;
      lat_cnt <= 0;
    end
  end

  task automatic run(input logic [23:0] base, input logic [15:0] w [6], input int l, input bit inj);
    int cyc;
    logic [5:0] opc;
    logic [1:0] u;
    logic bg;
    logic [23:0] c, sn, ewc;
    logic [33:0] eoff;
    logic [1:0] ecode, eop;
    for (int i = 0; i < 6; i++) mem[base[5:0] + 6'(i)] = w[i];
    opc = w[0][5:0]; u = w[0][7:6]; bg = unit_1k[u];
    c   = {w[4][7:0], w[5]}; sn = {w[2][15:8], w[1]};
    ewc = w[4][15] ? c : 24'(34'(c) * (bg ? 34'd512 : 34'd256));
    eoff = 34'(sn) * (bg ? 34'd1024 : 34'd512);
    if (!unit_present[u]) ecode = 1;
    else if (opc == 1) ecode = 2;
    else if (opc != 0 && opc != 6'o36 && opc != 6'o42) ecode = 3;
    else ecode = 0;
    eop = (opc == 6'o36) ? 2'd1 : (opc == 6'o42) ? 2'd2 : 2'd0;
    lat = l; exp_base = base; k = 0;
    @(negedge clk); start = 1; base_addr = base;
    @(negedge clk);
    cyc = 0;
    while (!(done || err) && cyc < 100) begin
      if (inj && cyc == 1) begin start = 1; base_addr = base + 24'd8; end
      else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk(cyc == 6 * (l + 1), "R7 timing", cyc, 6 * (l + 1));
    chk(k == 6, "R1 count", k, 6);
    if (ecode == 0) begin
      chk(done && !err, "R6 accept", {done, err}, 2'b10);
      chk(d_maddr == {w[2][7:0], w[3]}, "R2 maddr", d_maddr, {w[2][7:0], w[3]});
      chk(d_wcnt == ewc, "R3 wcnt", d_wcnt, ewc);
      chk(d_devoff == eoff, "R4 devoff", d_devoff, eoff);
      chk(d_op == eop && d_unit == u && d_fmt == w[0][11:8], "R5 fields",
          {d_op, d_unit, d_fmt}, {eop, u, w[0][11:8]});
    end else begin
      chk(err && !done && err_code == ecode, "R6 reject", {done, err, err_code}, {2'b01, ecode});
    end
    @(negedge clk);
    chk(!done && !err && !busy && !mem_req, "R8 R7 quiet", {done, err, busy, mem_req}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w [6];
    logic [5:0] ops [6];
    int n;
    ops[0] = 0; ops[1] = 1; ops[2] = 6'o36; ops[3] = 6'o42; ops[4] = 7; ops[5] = 6'o77;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 3);
    #1;
    chk(!busy && !mem_req && !done && !err, "R9 reset", {busy, mem_req, done, err}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req && !done && !err, "R9 after reset", {busy, mem_req, done, err}, 0);
    n = 0;
    for (int u = 0; u < 4; u++)
      for (int o = 0; o < 6; o++)
        for (int f = 0; f < 2; f++) begin
          w[0] = 16'((n * 16'h0537) & 16'hF000) | 16'(((n % 16) << 8)) | 16'(u << 6) | 16'(ops[o]);
          w[1] = 16'h1234 ^ 16'(n * 16'h0777);
          w[2] = 16'hA55A + 16'(n * 16'h0101);
          w[3] = 16'h0F0F ^ 16'(n * 16'h1111);
          w[4] = (f ? 16'h8000 : 16'h0000) | 16'((n * 16'h3D) & 16'h7FFF);
          w[5] = (n == 5) ? 16'hFFFF : 16'(n * 16'h2468);
          run(24'(8 + (n % 6) * 8), w, n % 3, (n % 5) == 0);
          n++;
        end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule